// File: doc/BRIEF.md
# Threshold-Driven Byte Transfer Queue

This block is a sixteen-entry byte queue that sits between a disk data engine and a host. It carries data either from the disk side to the host or from the host to the disk side. A programmable threshold decides how full (or how empty) the queue must get before the host is asked for service. The request goes out as an interrupt in programmed-I/O mode or as a DMA request in DMA mode, and a ready flag goes with it in both modes. Once raised, the request stays up until the host has emptied the queue (disk-to-host) or filled it (host-to-disk).

Configuration comes from four inputs:
- A queue-enable bit. When it is clear, the queue behaves as a one-byte holding register and data moves one byte per transfer.
- A 4-bit threshold code. The effective threshold is the code plus one.
- A DMA-enable bit.
- A burst bit that chooses between burst DMA and single-transfer DMA.

The disk side marks the final byte of a sector. That mark forces a request even when the fill level is below the threshold. Overruns and underruns are refused and recorded in a sticky error flag.

Top module: `xfer_fifo`

## Requirements
- R1: After reset the fill count is 0, and `rqm`, `irq`, `dma_req` and `xfer_err` are all 0.
- R2: Bytes leave the queue in the order they were accepted. The head byte appears on `host_rdata` and `dsk_rdata`.
- R3: With `cfg_fifo_en`=0 the queue holds at most one byte. A second push without a pop is refused.
- R4: In disk-to-host direction (`dir_to_host`=1) the request rises in the same cycle that the fill count reaches L. L = 16 − (code+1), with a minimum of 1. With the queue disabled, L = 1.
- R5: In host-to-disk direction (`dir_to_host`=0) the request rises in the same cycle that the number of free entries reaches L.
- R6: A disk push with `dsk_last`=1 raises the request in disk-to-host direction regardless of L. The forced condition ends when the queue empties.
- R7: Once raised, the request holds until the fill count is 0 (disk-to-host) or the queue is full (host-to-disk). It drops in that same cycle.
- R8: With `cfg_dma_en`=0 the request appears on `irq`. With `cfg_dma_en`=1 it appears on `dma_req`. `irq` and `dma_req` are never high together, and `rqm` follows the request in both modes.
- R9: In single-transfer DMA (`cfg_burst`=0), `dma_req` is low in the cycle after each `dma_ack`. It returns in the following cycle if the request is still pending.
- R10: In burst DMA (`cfg_burst`=1), `dma_req` stays high through consecutive acknowledges until the queue empties or fills.
- R11: A push to a full queue or a pop from an empty queue leaves the contents and count unchanged and sets `xfer_err`. `xfer_err` stays set until reset.
- R12: An accepted push and an accepted pop in the same cycle leave the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_fifo_en | input | 1 | 1: 16-entry queue; 0: one-byte holding |
| cfg_thr_code | input | 4 | Threshold code; effective threshold is code+1 |
| cfg_dma_en | input | 1 | 1: service by DMA request; 0: by interrupt |
| cfg_burst | input | 1 | 1: burst DMA; 0: single-transfer DMA |
| dir_to_host | input | 1 | 1: disk-to-host; 0: host-to-disk |
| dsk_push | input | 1 | Disk side writes a byte (disk-to-host) |
| dsk_wdata | input | 8 | Byte from the disk side |
| dsk_last | input | 1 | Pushed byte ends a sector |
| dsk_pop | input | 1 | Disk side takes a byte (host-to-disk) |
| dsk_rdata | output | 8 | Head byte toward the disk side |
| host_wr | input | 1 | Host data-register write (host-to-disk) |
| host_rd | input | 1 | Host data-register read (disk-to-host) |
| host_wdata | input | 8 | Byte from the host or DMA |
| host_rdata | output | 8 | Head byte toward the host |
| dma_ack | input | 1 | DMA acknowledge; moves one byte in the current direction |
| fill | output | 5 | Bytes held |
| rqm | output | 1 | Ready-for-service flag |
| irq | output | 1 | Interrupt request (programmed-I/O mode) |
| dma_req | output | 1 | DMA request |
| xfer_err | output | 1 | Sticky overrun/underrun flag |

## Verification
A wrong fill count shows up on `fill` at the next clock edge. Within a few transfers it also shows up as a request that rises at the wrong level, or as a request that drops before the queue has emptied or filled. A corrupted pointer shows up as soon as the affected entry reaches the head, as a byte out of order on the read data ports. A stuck request latch or a wrong DMA gap register shows up in the first cycle after an acknowledge, on `dma_req`.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  typedef enum logic {
    XD_TO_DISK = 1'b0,
    XD_TO_HOST = 1'b1
  } xfer_dir_e;

  // fill (or free) level at which service is asked for
  function automatic int unsigned trig_level(int unsigned depth,
                                             int unsigned code,
                                             bit          en);
    int unsigned thr;
    thr = code + 1;
    if (!en || thr >= depth) return 1;
    return depth - thr;
  endfunction

endpackage

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head
);

  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [PW-1:0] wr_ptr, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr, rd_ptr_nxt;
  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    if (push_ok) wr_ptr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr_nxt;
      if (pop_ok)  rd_ptr <= rd_ptr_nxt;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic we;
    assign we = push_ok && (wr_ptr == PW'(gi));
    always_ff @(posedge clk) begin
      if (we) mem[gi] <= wdata;
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/xfer_fifo_level.sv
module xfer_fifo_level #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [CW-1:0] cap,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          err
);

  logic err_nxt;
  logic cnt_en;

  always_comb begin
    push_ok   = push_req && (count < cap);
    pop_ok    = pop_req && (count != '0);
    count_nxt = count;
    case ({push_ok, pop_ok})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
    cnt_en  = push_ok ^ pop_ok;
    err_nxt = err | (push_req & ~push_ok) | (pop_req & ~pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      if (cnt_en) count <= count_nxt;
      err <= err_nxt;
    end
  end

endmodule

// File: rtl/xfer_fifo_req.sv
module xfer_fifo_req #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          to_host,
  input  logic [CW-1:0] count_nxt,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] lvl,
  input  logic          push_ok,
  input  logic          last_in,
  input  logic          dma_en,
  input  logic          burst,
  input  logic          dma_ack,
  output logic          rqm,
  output logic          irq,
  output logic          dma_req
);

  import xfer_fifo_pkg::*;

  xfer_dir_e     dir;
  logic          req_q, req_nxt;
  logic          eos_q, eos_nxt;
  logic          gap_q, gap_nxt;
  logic          clr_c, set_c;
  logic [CW-1:0] free_nxt;

  always_comb begin
    dir      = to_host ? XD_TO_HOST : XD_TO_DISK;
    free_nxt = (count_nxt >= cap) ? '0 : cap - count_nxt;
    eos_nxt  = 1'b0;
    if (dir == XD_TO_HOST) begin
      if (count_nxt == '0)          eos_nxt = 1'b0;
      else if (push_ok && last_in)  eos_nxt = 1'b1;
      else                          eos_nxt = eos_q;
    end
    if (dir == XD_TO_HOST) begin
      clr_c = (count_nxt == '0);
      set_c = (count_nxt >= lvl) || eos_nxt;
    end else begin
      clr_c = (count_nxt >= cap);
      set_c = (free_nxt >= lvl);
    end
    if (clr_c)      req_nxt = 1'b0;
    else if (set_c) req_nxt = 1'b1;
    else            req_nxt = req_q;
    gap_nxt = dma_ack && dma_en && !burst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      eos_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
      eos_q <= eos_nxt;
      gap_q <= gap_nxt;
    end
  end

  assign rqm     = req_q;
  assign irq     = req_q && !dma_en;
  assign dma_req = req_q && dma_en && !gap_q;

endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THR_W = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fifo_en,
  input  logic [THR_W-1:0] cfg_thr_code,
  input  logic             cfg_dma_en,
  input  logic             cfg_burst,
  input  logic             dir_to_host,
  input  logic             dsk_push,
  input  logic [DW-1:0]    dsk_wdata,
  input  logic             dsk_last,
  input  logic             dsk_pop,
  output logic [DW-1:0]    dsk_rdata,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             dma_ack,
  output logic [CW-1:0]    fill,
  output logic             rqm,
  output logic             irq,
  output logic             dma_req,
  output logic             xfer_err
);

  import xfer_fifo_pkg::*;

  logic [1:0]    rst_pipe;
  logic          rst_q;
  logic          push_req, pop_req, push_ok, pop_ok;
  logic [DW-1:0] wdata, head;
  logic [CW-1:0] cap, lvl, count_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  always_comb begin
    push_req = dir_to_host ? dsk_push : (host_wr | dma_ack);
    pop_req  = dir_to_host ? (host_rd | dma_ack) : dsk_pop;
    wdata    = dir_to_host ? dsk_wdata : host_wdata;
    cap      = cfg_fifo_en ? CW'(DEPTH) : CW'(1);
    lvl      = CW'(trig_level(DEPTH, 32'(cfg_thr_code), cfg_fifo_en));
  end

  xfer_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_q),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .wdata   (wdata),
    .head    (head)
  );

  xfer_fifo_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk       (clk),
    .rst_n     (rst_q),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .cap       (cap),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .count     (fill),
    .count_nxt (count_nxt),
    .err       (xfer_err)
  );

  xfer_fifo_req #(.DEPTH(DEPTH), .CW(CW)) u_req (
    .clk       (clk),
    .rst_n     (rst_q),
    .to_host   (dir_to_host),
    .count_nxt (count_nxt),
    .cap       (cap),
    .lvl       (lvl),
    .push_ok   (push_ok),
    .last_in   (dsk_last),
    .dma_en    (cfg_dma_en),
    .burst     (cfg_burst),
    .dma_ack   (dma_ack),
    .rqm       (rqm),
    .irq       (irq),
    .dma_req   (dma_req)
  );

  assign dsk_rdata  = head;
  assign host_rdata = head;

endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_fifo_en,
  input logic          cfg_dma_en,
  input logic          cfg_burst,
  input logic          dir_to_host,
  input logic          push_req,
  input logic          pop_req,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          dma_ack,
  input logic [CW-1:0] fill,
  input logic          rqm,
  input logic          irq,
  input logic          dma_req,
  input logic          xfer_err
);

  logic [CW-1:0] cap_c;
  assign cap_c = cfg_fifo_en ? CW'(DEPTH) : CW'(1);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R11

  AST_NO_GROW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && fill >= cap_c) |=> (fill == $past(fill))); // R11

  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fill == '0) |=> xfer_err); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> xfer_err); // R11

  AST_IRQ_DMA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req)); // R8

  AST_SINGLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && cfg_dma_en && !cfg_burst) |=> !dma_req); // R9

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_to_host && $stable(dir_to_host) && fill == '0) |-> !rqm); // R7

  AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(fill)); // R12

endmodule

bind xfer_fifo xfer_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .cfg_fifo_en (cfg_fifo_en),
  .cfg_dma_en  (cfg_dma_en),
  .cfg_burst   (cfg_burst),
  .dir_to_host (dir_to_host),
  .push_req    (push_req),
  .pop_req     (pop_req),
  .push_ok     (push_ok),
  .pop_ok      (pop_ok),
  .dma_ack     (dma_ack),
  .fill        (fill),
  .rqm         (rqm),
  .irq         (irq),
  .dma_req     (dma_req),
  .xfer_err    (xfer_err)
);

// File: tb/sim_xfer_fifo.sv
`timescale 1ns/100ps
module sim_xfer_fifo;

  logic       clk;
  logic       rst_n;
  logic       cfg_fifo_en, cfg_dma_en, cfg_burst, dir_to_host;
  logic [3:0] cfg_thr_code;
  logic       dsk_push, dsk_last, dsk_pop, host_wr, host_rd, dma_ack;
  logic [7:0] dsk_wdata, host_wdata, dsk_rdata, host_rdata;
  logic [4:0] fill;
  logic       rqm, irq, dma_req, xfer_err;

  int         checks = 0;
  int         errors = 0;
  logic [7:0] exp_q[$];
  logic       mon_pop;
  logic [7:0] mon_data;

  xfer_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thr_code(cfg_thr_code),
    .cfg_dma_en(cfg_dma_en), .cfg_burst(cfg_burst), .dir_to_host(dir_to_host),
    .dsk_push(dsk_push), .dsk_wdata(dsk_wdata), .dsk_last(dsk_last), .dsk_pop(dsk_pop),
    .dsk_rdata(dsk_rdata), .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dma_ack(dma_ack), .fill(fill), .rqm(rqm), .irq(irq),
    .dma_req(dma_req), .xfer_err(xfer_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: compares every popped byte with the scoreboard (R2)
  always begin
    @(negedge clk);
    #1;
    mon_pop  = dir_to_host ? (host_rd | dma_ack) : dsk_pop;
    mon_data = dir_to_host ? host_rdata : dsk_rdata;
    if (rst_n && mon_pop && exp_q.size() > 0) chk("R2 byte order", int'(mon_data), int'(exp_q.pop_front()));
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  function automatic int level_of(input int code, input bit en);
    if (!en || code + 1 >= 16) return 1;
    return 16 - (code + 1);
  endfunction

  task automatic do_reset(input bit en, input int code, input bit dma, input bit bst);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_fifo_en = en; cfg_thr_code = 4'(code); cfg_dma_en = dma; cfg_burst = bst;
    dir_to_host = 1'b1;
    dsk_push = 0; dsk_last = 0; dsk_pop = 0; host_wr = 0; host_rd = 0; dma_ack = 0;
    dsk_wdata = 0; host_wdata = 0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_disk(input logic [7:0] b, input bit last, input bit acc);
    @(negedge clk);
    dsk_push = 1; dsk_wdata = b; dsk_last = last;
    if (acc) exp_q.push_back(b);
    @(negedge clk);
    dsk_push = 0; dsk_last = 0;
  endtask

  task automatic read_host();
    @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic write_host(input logic [7:0] b);
    @(negedge clk);
    host_wr = 1; host_wdata = b;
    exp_q.push_back(b);
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic pop_disk();
    @(negedge clk);
    dsk_pop = 1;
    @(negedge clk);
    dsk_pop = 0;
  endtask

  initial begin
    int lv;
    rst_n = 1'b1;
    // R1 reset state
    do_reset(1, 11, 0, 0);
    chk("R1 fill", fill, 0);
    chk("R1 rqm", rqm, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 err", xfer_err, 0);

    // R4 level with code 11
    lv = level_of(11, 1);
    for (int i = 0; i < lv - 1; i++) push_disk(8'(8'h10 + i), 0, 1);
    chk("R4 below level rqm", rqm, 0);
    push_disk(8'h1f, 0, 1);
    chk("R4 at level rqm", rqm, 1);
    chk("R4 fill", fill, lv);
    chk("R8 irq in pio mode", irq, 1);
    chk("R8 dma_req in pio mode", dma_req, 0);
    for (int i = 0; i < lv - 1; i++) read_host();
    chk("R7 held until empty", rqm, 1);
    read_host();
    chk("R7 drop at empty", rqm, 0);
    chk("R7 fill empty", fill, 0);

    // R4 code 15 gives level 1
    do_reset(1, 15, 0, 0);
    push_disk(8'h21, 0, 1);
    chk("R4 code15 rqm", rqm, 1);
    read_host();
    chk("R4 code15 drained", rqm, 0);

    // R4 code 0 gives level 15, then R11 overrun/underrun
    do_reset(1, 0, 0, 0);
    lv = level_of(0, 1);
    for (int i = 0; i < lv - 1; i++) push_disk(8'(8'h30 + i), 0, 1);
    chk("R4 code0 below", rqm, 0);
    push_disk(8'h3e, 0, 1);
    chk("R4 code0 at level", rqm, 1);
    push_disk(8'h3f, 0, 1);
    chk("R11 full fill", fill, 16);
    chk("R11 no err yet", xfer_err, 0);
    push_disk(8'hee, 0, 0);
    chk("R11 overrun err", xfer_err, 1);
    chk("R11 overrun fill", fill, 16);
    for (int i = 0; i < 16; i++) read_host();
    chk("R11 drained fill", fill, 0);
    chk("R11 drained rqm", rqm, 0);
    read_host();
    chk("R11 underrun fill", fill, 0);
    chk("R11 err sticky", xfer_err, 1);

    // R6 end of sector forcing
    do_reset(1, 0, 0, 0);
    push_disk(8'h41, 0, 1);
    chk("R6 no force yet", rqm, 0);
    push_disk(8'h42, 1, 1);
    chk("R6 forced request", rqm, 1);
    read_host();
    chk("R6 held", rqm, 1);
    read_host();
    chk("R6 cleared at empty", rqm, 0);
    push_disk(8'h43, 0, 1);
    chk("R6 force does not linger", rqm, 0);
    read_host();

    // R3 disabled queue
    do_reset(0, 11, 0, 0);
    push_disk(8'h51, 0, 1);
    chk("R3 one byte fill", fill, 1);
    chk("R3 one byte rqm", rqm, 1);
    push_disk(8'h52, 0, 0);
    chk("R3 second refused fill", fill, 1);
    chk("R3 second refused err", xfer_err, 1);
    read_host();
    chk("R3 drained", fill, 0);

    // R5 host-to-disk
    do_reset(1, 11, 0, 0);
    lv = level_of(11, 1);
    @(negedge clk);
    dir_to_host = 1'b0;
    @(negedge clk);
    chk("R5 empty request", rqm, 1);
    for (int i = 0; i < 15; i++) write_host(8'(8'h60 + i));
    chk("R7 held until full", rqm, 1);
    write_host(8'h6f);
    chk("R7 drop at full", rqm, 0);
    chk("R7 full fill", fill, 16);
    for (int i = 0; i < lv - 1; i++) pop_disk();
    chk("R5 below free level", rqm, 0);
    pop_disk();
    chk("R5 at free level", rqm, 1);
    for (int i = 0; i < 16 - lv; i++) pop_disk();
    @(negedge clk);
    dir_to_host = 1'b1;

    // R9 single-transfer DMA
    do_reset(1, 11, 1, 0);
    lv = level_of(11, 1);
    for (int i = 0; i < lv; i++) push_disk(8'(8'h70 + i), 0, 1);
    chk("R8 dma_req in dma mode", dma_req, 1);
    chk("R8 irq in dma mode", irq, 0);
    @(negedge clk); dma_ack = 1;
    @(negedge clk); dma_ack = 0;
    chk("R9 gap after ack", dma_req, 0);
    chk("R9 fill after ack", fill, lv - 1);
    @(negedge clk);
    chk("R9 request back", dma_req, 1);
    for (int i = 0; i < lv - 1; i++) begin
      @(negedge clk); dma_ack = 1;
      @(negedge clk); dma_ack = 0;
    end
    chk("R9 drained", fill, 0);

    // R10 burst DMA
    do_reset(1, 11, 1, 1);
    lv = level_of(11, 1);
    for (int i = 0; i < lv; i++) push_disk(8'(8'h80 + i), 0, 1);
    @(negedge clk); dma_ack = 1;
    @(negedge clk);
    chk("R10 held through ack", dma_req, 1);
    chk("R10 fill", fill, lv - 1);
    @(negedge clk); dma_ack = 0;
    chk("R10 held second ack", dma_req, 1);
    @(negedge clk); dma_ack = 1;
    repeat (2) @(negedge clk);
    dma_ack = 0;
    chk("R10 drop at empty", dma_req, 0);
    chk("R10 empty", fill, 0);

    // R12 simultaneous push and pop
    do_reset(1, 11, 0, 0);
    push_disk(8'h91, 0, 1);
    push_disk(8'h92, 0, 1);
    @(negedge clk);
    dsk_push = 1; dsk_wdata = 8'h93; host_rd = 1;
    exp_q.push_back(8'h93);
    @(negedge clk);
    dsk_push = 0; host_rd = 0;
    chk("R12 fill unchanged", fill, 2);
    read_host();
    read_host();
    chk("R12 drained", fill, 0);

    report();
    $finish;
  end

endmodule